// File: doc/BRIEF.md
# Microprogrammed Control Sequencer for a Repeated-Addition Multiplier

This block is the control unit for a small 4-bit multiplier. The multiplier computes a product by adding the multiplicand into an accumulator once for each count of the multiplier. The block drives seven datapath control lines, C0 to C6. It does this from a fixed six-word microprogram held in a computed control store. There is no hard-coded state machine. Each 12-bit microword carries three fields: a 2-bit condition select, a 3-bit branch target and seven control bits. A micro-program counter either takes the branch target or steps forward by one. A condition multiplexer makes that choice from the select field and the datapath's zero flag.

The control lines mean the following:

| Line | Datapath action |
|------|-----------------|
| C0 | Clear the accumulator |
| C1 | Load the multiplicand from the input bus |
| C2 | Load the multiplier from the input bus |
| C3 | Form the accumulator-plus-multiplicand sum |
| C4 | Decrement the multiplier |
| C5 | Drive the accumulator onto the output bus |
| C6 | Store the sum into the accumulator |

The loop runs until the multiplier count reaches zero. The sequencer then presents the result once and parks on a word that branches to itself. A `done` pin marks that parked state. The datapath samples the control lines on each rising clock edge. The zero flag must reflect the datapath registers as they stand after that edge.

The block has no data stream of its own. Its pins are plain control and status lines, so no valid/ready handshake or back-pressure rule applies.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, the micro-program counter is held at address 0. The outputs show word 0 (`ctl` = 7'b0000011, that is, C0 and C1 high) and `done` is low. Word 0 stays on the outputs for the first cycle after reset is released.
- R2: A microword is 12 bits. Bits [11:10] are the condition select, bits [9:7] are the branch target and bits [6:0] are the control field, with C0 in bit 6 down to C6 in bit 0. Output `ctl[i]` carries line Ci.
- R3: The condition selects are decoded as follows. 2'b00 never branches. 2'b01 branches when `zero_flag` is 0. 2'b10 always branches. The unused code 2'b11 never branches.
- R4: When the condition holds, the counter loads the branch target. Otherwise it increments. The newly addressed word appears on `ctl` after the same clock edge that updates the counter.
- R5: After reset the words run in the order 0, 1, 2, 3. Word 1 drives C2 (7'b0000100). Word 2 drives C3, C4 and C6 (7'b1011000). Word 3 drives nothing.
- R6: While word 3 is current, a low `zero_flag` returns the sequence to word 2 and a high `zero_flag` moves it to word 4. Word 4 drives C5 (7'b0100000).
- R7: Word 5 branches to itself unconditionally and drives no control line. `done` is high exactly while word 5 is current.
- R8: `zero_flag` is sampled only while word 3 is current. Its value in any other word, including the parked word 5, has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_flag | input | 1 | High when the datapath multiplier count is zero |
| ctl | output | 7 | Control lines, bit i = Ci |
| done | output | 1 | High while the sequencer is parked on its halt word |

## Verification
The bench builds the block with its default parameters: a 3-bit address, six control-store words and halt address 5. With these values every stored word is reachable, and so are both outcomes of the zero test. A behavioural datapath in the bench closes the loop. It runs multiplier values of 0 (sixteen passes, wrapping the count), 1 and 15, which cover the shortest and the longest loops. On half of the runs the bench inverts `zero_flag` pseudo-randomly in every word except word 3. This shows that only the testing word listens to the flag.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int COND_W = 2;
  localparam int BR_W   = 3;
  localparam int CTL_W  = 7;
  localparam int WORD_W = COND_W + BR_W + CTL_W;

  typedef enum logic [COND_W-1:0] {
    COND_STEP = 2'b00,  // never branch
    COND_NZ   = 2'b01,  // branch while the zero flag is low
    COND_JUMP = 2'b10,  // always branch
    COND_RSV  = 2'b11   // unused: treated as never branch
  } cond_e;

  typedef struct packed {
    cond_e             cond;
    logic [BR_W-1:0]   br;
    logic [CTL_W-1:0]  ctl;   // bit CTL_W-1 = C0 ... bit 0 = C6
  } uword_t;

  // Microprogram, computed per address; anything past the end reads as a no-op.
  function automatic uword_t program_word(input int addr);
    uword_t w;
    w = '{cond: COND_STEP, br: '0, ctl: '0};
    case (addr)
      0: w.ctl = 7'b1100000;                          // clear acc, load multiplicand
      1: w.ctl = 7'b0010000;                          // load multiplier
      2: w.ctl = 7'b0001101;                          // add, decrement, store
      3: begin w.cond = COND_NZ;   w.br = 3'd2; end   // loop test
      4: w.ctl = 7'b0000010;                          // present result
      5: begin w.cond = COND_JUMP; w.br = 3'd5; end   // park
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);

  localparam int SLOTS = 1 << ADDR_W;

  uword_t rom [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_word
    if (i < DEPTH) begin : g_used
      assign rom[i] = program_word(i);
    end else begin : g_blank
      assign rom[i] = '{cond: COND_STEP, br: '0, ctl: '0};
    end
  end

  assign word = rom[addr];

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_flag,
  input  cond_e             cur_cond,
  input  logic [BR_W-1:0]   cur_br,
  output logic [ADDR_W-1:0] mpc,
  output logic [ADDR_W-1:0] nxt
);

  logic take;

  // Condition multiplexer.
  always_comb begin
    unique case (cur_cond)
      COND_STEP: take = 1'b0;
      COND_NZ:   take = ~zero_flag;
      COND_JUMP: take = 1'b1;
      default:   take = 1'b0;
    endcase
  end

  // Load or increment.
  always_comb begin
    if (take) nxt = ADDR_W'(cur_br);
    else      nxt = mpc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mpc <= '0;
    else        mpc <= nxt;
  end

  a_r3_step_never_branches: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_STEP || cur_cond == COND_RSV) |=> mpc == $past(mpc) + 1'b1);

  a_r3_jump_always_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_JUMP) |=> mpc == ADDR_W'($past(cur_br)));

  a_r6_loop_while_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_NZ && !zero_flag) |=> mpc == ADDR_W'($past(cur_br)));

  a_r6_exit_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_NZ && zero_flag) |=> mpc == $past(mpc) + 1'b1);

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mpc) < DEPTH);

endmodule

// File: rtl/useq_cwr.sv
module useq_cwr
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  uword_t           fetched,
  output uword_t           cur,
  output logic [CTL_W-1:0] lines
);

  localparam uword_t RESET_WORD = program_word(0);

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= RESET_WORD;
    else        cur <= fetched;
  end

  // Field stores C0 in its top bit; port bit i carries Ci.
  for (genvar i = 0; i < CTL_W; i++) begin : g_line
    assign lines[i] = cur.ctl[CTL_W-1-i];
  end

  a_r4_word_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cur == $past(fetched));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DEPTH     = 6,
  parameter int HALT_ADDR = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_flag,
  output logic [CTL_W-1:0] ctl,
  output logic             done
);

  logic [ADDR_W-1:0] mpc;
  logic [ADDR_W-1:0] nxt;
  uword_t            fetched;
  uword_t            cur;

  useq_next #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_next (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_flag (zero_flag),
    .cur_cond  (cur.cond),
    .cur_br    (cur.br),
    .mpc       (mpc),
    .nxt       (nxt)
  );

  useq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .addr (nxt),
    .word (fetched)
  );

  useq_cwr u_cwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .fetched (fetched),
    .cur     (cur),
    .lines   (ctl)
  );

  assign done = (mpc == ADDR_W'(HALT_ADDR));

  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mpc == '0 && ctl == 7'b0000011 && !done));

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctl == '0);

  a_r5_order_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mpc == '0) |=> mpc == ADDR_W'(1));

endmodule

// File: tb/useq_ctrl_bench.sv
`timescale 1ns/1ps
module useq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zero_flag;
  logic [6:0] ctl;
  logic       done;

  always #4 clk = ~clk;  // 125 MHz

  useq_ctrl u_useq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_flag (zero_flag),
    .ctl       (ctl),
    .done      (done)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Behavioural datapath
  logic [3:0] dp_r = '0, dp_m = '0, dp_q = '0, dp_out = '0;
  logic       noise = 1'b0;
  logic [7:0] lfsr  = 8'hA5;
  assign zero_flag = (dp_q == 4'd0) ^ noise;

  function automatic logic [6:0] expect_ctl(input int t);
    case (t)
      0: return 7'b0000011;
      1: return 7'b0000100;
      2: return 7'b1011000;
      4: return 7'b0100000;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic string tag_of(input int t);
    case (t)
      0: return "R1";
      1, 2: return "R5";
      3: return "R8";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input logic [3:0] mcand, input logic [3:0] mplier, input bit use_noise);
    int t = 0;
    int tail = 0;
    rst_n = 1'b0;
    noise = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset ctl", {1'b0, ctl}, 8'h03);
    check("R1 reset done", {7'b0, done}, 8'h00);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 300 && tail < 4; cyc++) begin
      logic [6:0] c;
      logic       z;
      logic [3:0] inbus, f;
      if (cyc > 0) @(negedge clk);
      // R8: the flag is only meaningful in the test word
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      noise = (use_noise && t != 3) ? lfsr[0] : 1'b0;
      #1;
      check({tag_of(t), " ctl R2"}, {1'b0, ctl}, {1'b0, expect_ctl(t)});
      check("R7 done", {7'b0, done}, {7'b0, (t == 5)});
      c = ctl;
      z = zero_flag;
      @(posedge clk);
      #1;
      inbus = c[1] ? mcand : mplier;
      f = dp_r + dp_m;
      if (c[0]) dp_r = '0;
      if (c[6]) dp_r = f;
      if (c[1]) dp_m = inbus;
      if (c[2]) dp_q = inbus;
      if (c[4]) dp_q = dp_q - 1'b1;
      if (c[5]) dp_out = dp_r;
      case (t)
        3:       t = z ? 4 : 2;  // R3 R4 R6
        5:       t = 5;
        default: t = t + 1;
      endcase
      if (t == 5) tail++;
    end
    check("R6 product", {4'b0, dp_out}, {4'b0, 4'(mcand * mplier)});
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    run(4'd3,  4'd5,  1'b0);
    run(4'd7,  4'd0,  1'b0);
    run(4'd15, 4'd15, 1'b1);
    run(4'd0,  4'd9,  1'b1);
    run(4'd5,  4'd1,  1'b1);
    run(4'd9,  4'd15, 1'b0);
    // R1: reset from the parked state returns to word 0
    run(4'd2,  4'd3,  1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule